// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block resolves a virtual address into a physical address after a translation buffer miss. It descends a four-level radix tree held in memory, issuing one 8-byte read per level through a single request/response memory port, and returns either the physical address of the target byte or a fault together with the level where the walk stopped. Pages of 4KB are mapped at the lowest level; 2MB pages may be mapped one level above it.

A walk normally begins at the top level using the root table page number supplied on a plain control input. A requester that already knows an intermediate table (for example from a partial-translation cache) may instead name the starting level and the page number of that table, and the walker then skips the levels above it. Only one walk is in flight at a time.

Requests use valid/ready: a request is taken on a cycle where both are high, and `req_ready` is high only while the walker is idle, so a requester must hold its request until accepted. The memory read request is also valid/ready, and its address is held stable while stalled. The memory response has no back-pressure; the walker only expects it while it waits for a read. The result is valid/ready: it stays valid and unchanged until the consumer raises `res_ready`.

Top module: `radix_walker`

## Requirements
- R1: Each read address is the 40-bit table page number in bits 51:12, the 9-bit index for the current level in bits 11:3, and zero in bits 2:0; a walk started at the top level uses `root_ppn` as its first table page number.
- R2: The index for level 3 (top) is vaddr bits 47:39, level 2 uses 38:30, level 1 uses 29:21, level 0 uses 20:12; levels are read from higher to lower, each next table page number taken from bits 51:12 of the entry just read.
- R3: A valid entry read at level 0 ends the walk with no fault, large flag 0, and physical address equal to entry bits 51:12 followed by vaddr bits 11:0, after one read per level walked.
- R4: A valid level-1 entry with bit 7 set ends the walk after that read as a 2MB mapping: large flag 1, physical address bits 51:21 from entry bits 51:21 and bits 20:0 from vaddr; bit 7 has no effect at levels 3, 2 and 0.
- R5: An entry with bit 0 clear ends the walk with a fault reporting that entry's level, and no further read is issued.
- R6: If vaddr bits 63:48 are not all equal to bit 47, the request faults at level 3 with no read issued; a correctly sign-extended upper-half address walks normally.
- R7: A request with a start level below 3 uses `req_start_ppn` as the first table page number and performs its first read at that level.
- R8: `req_ready` is high exactly when no walk is in progress and no result is pending; no memory read or result is presented while it is high.
- R9: While `res_valid` is high and `res_ready` low, the result stays valid and its fields do not change.
- R10: While `mem_req_valid` is high and `mem_req_ready` low, the read request stays valid with an unchanged address.
- R11: After reset, `req_ready` is 1 and `mem_req_valid` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_start_level | input | 2 | Level at which to begin (3 = top) |
| req_start_ppn | input | 40 | Table page number used when starting below the top |
| root_ppn | input | 40 | Root table page number (control register value) |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_level | output | 2 | Level at which the fault occurred |
| res_large | output | 1 | Result maps a 2MB page |
| res_paddr | output | 52 | Translated physical address |

## Verification
The hardest situation to reach is a level-1 entry that carries the large-page flag being honoured while the same flag on entries at other levels is ignored, combined with walks that resume from an intermediate level. The bench builds a sparse page table in a memory model, places the flag deliberately at levels 2, 1 and 0, and launches walks both from the root and from supplied intermediate page numbers, comparing read counts and addresses. Memory-port stalls are forced by a back-pressure pattern during a repeated walk, and result back-pressure by withholding `res_ready`.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int unsigned RW_FULL_VA_W = 64;
  localparam int unsigned RW_VA_W      = 48;
  localparam int unsigned RW_PPN_W     = 40;
  localparam int unsigned RW_IDX_W     = 9;
  localparam int unsigned RW_OFF_W     = 12;
  localparam int unsigned RW_LEVELS    = 4;
  localparam int unsigned RW_PTE_W     = 64;
  localparam int unsigned RW_LARGE_LVL = 1;
  localparam int unsigned RW_VALID_BIT = 0;
  localparam int unsigned RW_LARGE_BIT = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/rw_entry_addr.sv
// Picks the index field for the current level and forms the entry byte address.
module rw_entry_addr #(
  parameter int unsigned VA_W   = rw_pkg::RW_VA_W,
  parameter int unsigned PPN_W  = rw_pkg::RW_PPN_W,
  parameter int unsigned IDX_W  = rw_pkg::RW_IDX_W,
  parameter int unsigned OFF_W  = rw_pkg::RW_OFF_W,
  parameter int unsigned LEVELS = rw_pkg::RW_LEVELS,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned PA_W  = PPN_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] table_ppn,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int unsigned ESZ_LOG2 = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx;
  logic             unused_va;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx = idx_arr[i];
    end
  end

  assign entry_addr = {table_ppn, idx, {ESZ_LOG2{1'b0}}};
  assign unused_va  = ^vaddr;
endmodule

// File: rtl/rw_pte_decode.sv
// Interprets a fetched entry: validity, leaf detection and leaf address.
module rw_pte_decode #(
  parameter int unsigned VA_W      = rw_pkg::RW_VA_W,
  parameter int unsigned PPN_W     = rw_pkg::RW_PPN_W,
  parameter int unsigned IDX_W     = rw_pkg::RW_IDX_W,
  parameter int unsigned OFF_W     = rw_pkg::RW_OFF_W,
  parameter int unsigned LEVELS    = rw_pkg::RW_LEVELS,
  parameter int unsigned PTE_W     = rw_pkg::RW_PTE_W,
  parameter int unsigned LARGE_LVL = rw_pkg::RW_LARGE_LVL,
  parameter int unsigned VALID_BIT = rw_pkg::RW_VALID_BIT,
  parameter int unsigned LARGE_BIT = rw_pkg::RW_LARGE_BIT,
  localparam int unsigned LVL_W    = $clog2(LEVELS),
  localparam int unsigned PA_W     = PPN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  vaddr,
  output logic             pte_valid,
  output logic             is_leaf,
  output logic             is_large,
  output logic [PPN_W-1:0] next_ppn,
  output logic [PA_W-1:0]  leaf_paddr
);
  localparam int unsigned SPAN_LG = OFF_W + IDX_W * LARGE_LVL;
  localparam logic [PA_W-1:0] MASK_LG = {PA_W{1'b1}} >> (PA_W - SPAN_LG);
  localparam logic [PA_W-1:0] MASK_SM = {PA_W{1'b1}} >> (PA_W - OFF_W);

  logic [PA_W-1:0] base;
  logic [PA_W-1:0] va_ext;
  logic [PA_W-1:0] mask;
  logic            unused_bits;

  assign next_ppn  = pte[OFF_W +: PPN_W];
  assign pte_valid = pte[VALID_BIT];
  assign is_large  = pte_valid && pte[LARGE_BIT] && (level == LVL_W'(LARGE_LVL));
  assign is_leaf   = pte_valid && ((level == '0) || is_large);

  assign base       = {next_ppn, {OFF_W{1'b0}}};
  assign va_ext     = PA_W'(vaddr);
  assign mask       = is_large ? MASK_LG : MASK_SM;
  assign leaf_paddr = (base & ~mask) | (va_ext & mask);

  assign unused_bits = ^{pte, vaddr};
endmodule

// File: rtl/rw_canon.sv
// Upper address bits must all repeat the top implemented bit.
module rw_canon #(
  parameter int unsigned FULL_W = rw_pkg::RW_FULL_VA_W,
  parameter int unsigned VA_W   = rw_pkg::RW_VA_W
) (
  input  logic [FULL_W-1:0] va,
  output logic              canon_ok
);
  logic [FULL_W-VA_W:0] upper;
  assign upper    = va[FULL_W-1:VA_W-1];
  assign canon_ok = (&upper) || !(|upper);
endmodule

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int unsigned FULL_VA_W = rw_pkg::RW_FULL_VA_W,
  parameter int unsigned VA_W      = rw_pkg::RW_VA_W,
  parameter int unsigned PPN_W     = rw_pkg::RW_PPN_W,
  parameter int unsigned IDX_W     = rw_pkg::RW_IDX_W,
  parameter int unsigned OFF_W     = rw_pkg::RW_OFF_W,
  parameter int unsigned LEVELS    = rw_pkg::RW_LEVELS,
  parameter int unsigned PTE_W     = rw_pkg::RW_PTE_W,
  parameter int unsigned LARGE_LVL = rw_pkg::RW_LARGE_LVL,
  parameter int unsigned VALID_BIT = rw_pkg::RW_VALID_BIT,
  parameter int unsigned LARGE_BIT = rw_pkg::RW_LARGE_BIT,
  localparam int unsigned LVL_W    = $clog2(LEVELS),
  localparam int unsigned PA_W     = PPN_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [FULL_VA_W-1:0] req_vaddr,
  input  logic [LVL_W-1:0]     req_start_level,
  input  logic [PPN_W-1:0]     req_start_ppn,
  input  logic [PPN_W-1:0]     root_ppn,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [PA_W-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [PTE_W-1:0]     mem_rsp_data,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_fault,
  output logic [LVL_W-1:0]     res_fault_level,
  output logic                 res_large,
  output logic [PA_W-1:0]      res_paddr
);
  import rw_pkg::*;

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      state_q;
  logic [LVL_W-1:0] level_q;
  logic [PPN_W-1:0] ppn_q;
  logic [VA_W-1:0]  va_q;
  logic             fault_q;
  logic [LVL_W-1:0] flvl_q;
  logic             large_q;
  logic [PA_W-1:0]  paddr_q;

  logic             canon_ok;
  logic             pte_valid;
  logic             is_leaf;
  logic             is_large;
  logic [PPN_W-1:0] next_ppn;
  logic [PA_W-1:0]  leaf_paddr;

  rw_canon #(.FULL_W(FULL_VA_W), .VA_W(VA_W)) u_canon (
    .va       (req_vaddr),
    .canon_ok (canon_ok)
  );

  rw_entry_addr #(
    .VA_W(VA_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_addr (
    .vaddr      (va_q),
    .level      (level_q),
    .table_ppn  (ppn_q),
    .entry_addr (mem_req_addr)
  );

  rw_pte_decode #(
    .VA_W(VA_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS),
    .PTE_W(PTE_W), .LARGE_LVL(LARGE_LVL), .VALID_BIT(VALID_BIT), .LARGE_BIT(LARGE_BIT)
  ) u_dec (
    .pte        (mem_rsp_data),
    .level      (level_q),
    .vaddr      (va_q),
    .pte_valid  (pte_valid),
    .is_leaf    (is_leaf),
    .is_large   (is_large),
    .next_ppn   (next_ppn),
    .leaf_paddr (leaf_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      level_q <= '0;
      ppn_q   <= '0;
      va_q    <= '0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      large_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr[VA_W-1:0];
            fault_q <= 1'b0;
            flvl_q  <= '0;
            large_q <= 1'b0;
            paddr_q <= '0;
            if (!canon_ok) begin
              fault_q <= 1'b1;
              flvl_q  <= TOP_LVL;
              state_q <= ST_DONE;
            end else begin
              level_q <= req_start_level;
              ppn_q   <= (req_start_level == TOP_LVL) ? root_ppn : req_start_ppn;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_valid) begin
              fault_q <= 1'b1;
              flvl_q  <= level_q;
              state_q <= ST_DONE;
            end else if (is_leaf) begin
              paddr_q <= leaf_paddr;
              large_q <= is_large;
              state_q <= ST_DONE;
            end else begin
              level_q <= level_q - LVL_W'(1);
              ppn_q   <= next_ppn;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_DONE: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign mem_req_valid   = (state_q == ST_ISSUE);
  assign res_valid       = (state_q == ST_DONE);
  assign res_fault       = fault_q;
  assign res_fault_level = flvl_q;
  assign res_large       = large_q;
  assign res_paddr       = paddr_q;
endmodule

// File: rtl/rw_checker.sv
module rw_checker #(
  parameter int unsigned FULL_VA_W = 64,
  parameter int unsigned VA_W      = 48,
  parameter int unsigned PPN_W     = 40,
  parameter int unsigned LVL_W     = 2,
  parameter int unsigned PA_W      = 52
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [FULL_VA_W-1:0] req_vaddr,
  input logic [LVL_W-1:0]     req_start_level,
  input logic [PPN_W-1:0]     root_ppn,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic [PA_W-1:0]      mem_req_addr,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic                 res_fault,
  input logic [LVL_W-1:0]     res_fault_level,
  input logic [PA_W-1:0]      res_paddr
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  logic va_canon;
  assign va_canon = (&req_vaddr[FULL_VA_W-1:VA_W-1]) || !(|req_vaddr[FULL_VA_W-1:VA_W-1]);

  AST_ROOT_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && va_canon && req_start_level == TOP)
      |=> (mem_req_valid && mem_req_addr[PA_W-1 -: PPN_W] == $past(root_ppn))); // R1

  AST_NO_READ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid); // R5

  AST_NONCANON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !va_canon)
      |=> (res_valid && res_fault && res_fault_level == TOP && !mem_req_valid)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready)
      |=> (res_valid && $stable(res_paddr) && $stable(res_fault) && $stable(res_fault_level))); // R9

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
endmodule

bind radix_walker rw_checker #(
  .FULL_VA_W(FULL_VA_W), .VA_W(VA_W), .PPN_W(PPN_W), .LVL_W(LVL_W), .PA_W(PA_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_vaddr       (req_vaddr),
  .req_start_level (req_start_level),
  .root_ppn        (root_ppn),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .res_valid       (res_valid),
  .res_ready       (res_ready),
  .res_fault       (res_fault),
  .res_fault_level (res_fault_level),
  .res_paddr       (res_paddr)
);

// File: tb/sim_radix_walker.sv
module sim_radix_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_start_level = 2'd3;
  logic [39:0] req_start_ppn = '0;
  logic [39:0] root_ppn = 40'h613;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic [1:0]  res_fault_level;
  logic        res_large;
  logic [51:0] res_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix_walker u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(logic [8:0] a, logic [8:0] b, logic [8:0] c,
                                       logic [8:0] d, logic [11:0] o);
    logic [47:0] v;
    v = {a, b, c, d, o};
    return {{16{v[47]}}, v};
  endfunction
  function automatic logic [51:0] pa4k(logic [39:0] p, logic [11:0] o);
    return {p, o};
  endfunction
  function automatic logic [51:0] pa2m(logic [39:0] p, logic [63:0] v);
    return {p[39:9], v[20:0]};
  endfunction

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  lvl;
    logic [39:0] bppn;
    logic        flt;
    logic [1:0]  flv;
    logic        lg;
    logic [51:0] pa;
    logic [3:0]  nrd;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [63:0] VA_A = mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c2, 12'h016);
  localparam logic [63:0] VA_B = mkva(9'h0b9, 9'h00d, 9'h0bd, 9'h091, 12'h5d7);
  localparam logic [63:0] VA_C = mkva(9'h03a, 9'h000, 9'h000, 9'h000, 12'h000);
  localparam logic [63:0] VA_D = mkva(9'h0b9, 9'h00c, 9'h0dd, 9'h0c3, 12'h929);
  localparam logic [63:0] VA_E = mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c5, 12'h000);
  localparam logic [63:0] VA_F = mkva(9'h0b9, 9'h00e, 9'h001, 9'h002, 12'h4a4);
  localparam logic [63:0] VA_G = mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c3, 12'h103);
  localparam logic [63:0] VA_H = mkva(9'h1a0, 9'h000, 9'h000, 9'h000, 12'h000);
  localparam logic [63:0] VA_N = 64'h0001_0000_0000_0000;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{VA_A, 2'd3, 40'h0,   1'b0, 2'd0, 1'b0, pa4k(40'h777, 12'h016), 4'd4, 4'd3}, // R3
    '{VA_B, 2'd3, 40'h0,   1'b0, 2'd0, 1'b1, pa2m(40'h1200, VA_B),   4'd3, 4'd4}, // R4
    '{VA_C, 2'd3, 40'h0,   1'b1, 2'd3, 1'b0, 52'h0,                  4'd1, 4'd5}, // R5
    '{VA_D, 2'd3, 40'h0,   1'b1, 2'd1, 1'b0, 52'h0,                  4'd3, 4'd5}, // R5
    '{VA_E, 2'd3, 40'h0,   1'b1, 2'd0, 1'b0, 52'h0,                  4'd4, 4'd5}, // R5
    '{VA_F, 2'd3, 40'h0,   1'b0, 2'd0, 1'b0, pa4k(40'h888, 12'h4a4), 4'd4, 4'd4}, // R4
    '{VA_G, 2'd3, 40'h0,   1'b0, 2'd0, 1'b0, pa4k(40'h999, 12'h103), 4'd4, 4'd4}, // R4
    '{VA_A, 2'd2, 40'h042, 1'b0, 2'd0, 1'b0, pa4k(40'h777, 12'h016), 4'd3, 4'd7}, // R7
    '{VA_A, 2'd1, 40'h125, 1'b0, 2'd0, 1'b0, pa4k(40'h777, 12'h016), 4'd2, 4'd7}, // R7
    '{VA_A, 2'd0, 40'h508, 1'b0, 2'd0, 1'b0, pa4k(40'h777, 12'h016), 4'd1, 4'd7}, // R7
    '{VA_B, 2'd1, 40'h300, 1'b0, 2'd0, 1'b1, pa2m(40'h1200, VA_B),   4'd1, 4'd7}, // R7
    '{VA_N, 2'd3, 40'h0,   1'b1, 2'd3, 1'b0, 52'h0,                  4'd0, 4'd6}, // R6
    '{VA_H, 2'd3, 40'h0,   1'b1, 2'd3, 1'b0, 52'h0,                  4'd1, 4'd6}  // R6
  };

  // memory model
  logic [63:0] pmem [logic [51:0]];
  int          rd_cnt = 0;
  logic [51:0] rd_log [16];
  logic        pend = 1'b0;
  logic [51:0] pend_addr = '0;
  logic        stall_en = 1'b0;
  int          cyc = 0;
  logic        prev_hold = 1'b0;
  logic [51:0] prev_addr = '0;
  int          hold_bad = 0;
  int          stall_seen = 0;

  task automatic set_pte(logic [39:0] tbl, logic [8:0] idx, logic [39:0] ppn,
                         logic vld, logic big);
    pmem[{tbl, idx, 3'b000}] = {12'h0, ppn, 4'h0, big, 6'h0, vld};
  endtask

  always @(negedge clk) begin
    logic rdy_nxt;
    rdy_nxt = !stall_en || (cyc % 3 == 0);
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= pmem.exists(pend_addr) ? pmem[pend_addr] : 64'h0;
      pend <= 1'b0;
    end
    if (prev_hold && (!mem_req_valid || mem_req_addr !== prev_addr)) hold_bad <= hold_bad + 1;
    prev_hold <= mem_req_valid && !rdy_nxt;
    prev_addr <= mem_req_addr;
    if (mem_req_valid && !rdy_nxt) stall_seen <= stall_seen + 1;
    if (mem_req_valid && rdy_nxt) begin
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      rd_log[rd_cnt % 16] <= mem_req_addr;
      rd_cnt    <= rd_cnt + 1;
    end
    mem_req_ready <= rdy_nxt;
  end

  logic        o_flt;
  logic [1:0]  o_flv;
  logic        o_lg;
  logic [51:0] o_pa;
  int          o_nrd;
  int          rd_base;
  logic        busy_ready;
  logic        held_ok;

  task automatic walk(logic [63:0] va, logic [1:0] lvl, logic [39:0] bppn, int hold);
    int guard;
    @(negedge clk);
    rd_base = rd_cnt;
    req_vaddr = va;
    req_start_level = lvl;
    req_start_ppn = bppn;
    req_valid = 1'b1;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    busy_ready = req_ready;
    guard = 0;
    while (!res_valid && guard < 200) begin @(negedge clk); guard++; end
    o_flt = res_fault; o_flv = res_fault_level; o_lg = res_large; o_pa = res_paddr;
    held_ok = 1'b1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!res_valid || res_paddr !== o_pa || res_fault !== o_flt || res_large !== o_lg)
        held_ok = 1'b0;
    end
    o_nrd = rd_cnt - rd_base;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    set_pte(40'h613, 9'h0b9, 40'h042, 1'b1, 1'b0);
    set_pte(40'h042, 9'h00c, 40'h125, 1'b1, 1'b0);
    set_pte(40'h125, 9'h0ae, 40'h508, 1'b1, 1'b0);
    set_pte(40'h508, 9'h0c2, 40'h777, 1'b1, 1'b0);
    set_pte(40'h508, 9'h0c3, 40'h999, 1'b1, 1'b1);
    set_pte(40'h125, 9'h0dd, 40'h005, 1'b0, 1'b0);
    set_pte(40'h042, 9'h00d, 40'h300, 1'b1, 1'b0);
    set_pte(40'h300, 9'h0bd, 40'h1200, 1'b1, 1'b1);
    set_pte(40'h042, 9'h00e, 40'h400, 1'b1, 1'b1);
    set_pte(40'h400, 9'h001, 40'h500, 1'b1, 1'b0);
    set_pte(40'h500, 9'h002, 40'h888, 1'b1, 1'b0);

    repeat (3) @(negedge clk);
    chk("R11 req_ready in reset", 64'(req_ready), 64'd1);
    chk("R11 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk("R11 res_valid in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 req_ready after reset", 64'(req_ready), 64'd1);

    foreach (VECS[i]) begin
      walk(VECS[i].va, VECS[i].lvl, VECS[i].bppn, 0);
      chk($sformatf("R%0d vec%0d fault", VECS[i].rq, i), 64'(o_flt), 64'(VECS[i].flt));
      chk($sformatf("R%0d vec%0d reads", VECS[i].rq, i), 64'(o_nrd), 64'(VECS[i].nrd));
      if (VECS[i].flt)
        chk($sformatf("R%0d vec%0d level", VECS[i].rq, i), 64'(o_flv), 64'(VECS[i].flv));
      else begin
        chk($sformatf("R%0d vec%0d paddr", VECS[i].rq, i), 64'(o_pa), 64'(VECS[i].pa));
        chk($sformatf("R%0d vec%0d large", VECS[i].rq, i), 64'(o_lg), 64'(VECS[i].lg));
      end
    end

    // R1 R2: address of each read of a full walk
    walk(VA_A, 2'd3, 40'h0, 0);
    chk("R1 read0 addr", 64'(rd_log[(rd_base + 0) % 16]), 64'({40'h613, 9'h0b9, 3'b000}));
    chk("R2 read1 addr", 64'(rd_log[(rd_base + 1) % 16]), 64'({40'h042, 9'h00c, 3'b000}));
    chk("R2 read2 addr", 64'(rd_log[(rd_base + 2) % 16]), 64'({40'h125, 9'h0ae, 3'b000}));
    chk("R2 read3 addr", 64'(rd_log[(rd_base + 3) % 16]), 64'({40'h508, 9'h0c2, 3'b000}));
    chk("R8 req_ready low while busy", 64'(busy_ready), 64'd0);

    // R7: first read of an intermediate start
    walk(VA_D, 2'd1, 40'h125, 0);
    chk("R7 start read addr", 64'(rd_log[rd_base % 16]), 64'({40'h125, 9'h0dd, 3'b000}));
    chk("R5 fault at start level", 64'(o_flv), 64'd1);

    // R9: result held under back-pressure
    walk(VA_B, 2'd3, 40'h0, 4);
    chk("R9 result held", 64'(held_ok), 64'd1);
    chk("R9 held paddr", 64'(o_pa), 64'(pa2m(40'h1200, VA_B)));

    // R10: memory request stalls
    stall_en = 1'b1;
    walk(VA_G, 2'd3, 40'h0, 0);
    stall_en = 1'b0;
    chk("R10 paddr under stall", 64'(o_pa), 64'(pa4k(40'h999, 12'h103)));
    chk("R10 reads under stall", 64'(o_nrd), 64'd4);
    chk("R10 stall occurred", 64'(stall_seen > 0), 64'd1);
    chk("R10 request held", 64'(hold_bad), 64'd0);

    @(negedge clk);
    chk("R8 idle after result taken", 64'(req_ready), 64'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule